// File: doc/BRIEF.md
# Two-Write, Six-Read Register File with Newest-Value Tags

The block is a small register file that accepts two independent writes and serves up to six reads in every clock cycle. Reads are combinational: the data for an address appears in the same cycle as the address. Storage is built from banks that each offer three combinational reads and one clocked write. Each write port owns a private group of banks, and that group holds enough copies to cover every read port. Neither write port ever drives the other's storage, so no priority multiplexer sits in front of the memories.

A flip-flop table keeps one bit per register address. The bit names the write port that most recently wrote that address. Each read port looks up this bit and takes its data from the matching bank group. If both ports write the same address in the same cycle, port B takes the address. A parameter can add one register stage to every read result.

Top module: `rf_lvt_top`

## Requirements
- R1: With `REG_OUT=0`, every read port returns the current contents of its addressed register combinationally, in the same cycle as the address.
- R2: A write through port A (`wa_en=1`) that does not collide with port B is visible from the next cycle onward, and its tag bit becomes 0 (port A).
- R3: A write through port B (`wb_en=1`) is visible from the next cycle onward, and its tag bit becomes 1 (port B).
- R4: If both ports write the same address in one cycle, the register afterwards holds port B's data.
- R5: A read of an address that is being written in the same cycle returns the value stored before the write.
- R6: Two writes to different addresses in one cycle both take effect.
- R7: With `REG_OUT=1`, each read result is the value the combinational path had one cycle earlier, and the outputs read 0 while reset is held.
- R8: Asserting `rst_n` low sets every tag bit to 0. After reset, every address reads the last value that port A stored there, and the storage itself is not cleared.
- R9: A port whose enable is 0 changes neither storage nor tags, whatever its address and data inputs carry.
- R10: The read ports are independent. Read port k uses address bits `[k*ADDR_W +: ADDR_W]` and data bits `[k*DATA_W +: DATA_W]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes, tags and output registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the tag table and output registers |
| wa_en | input | 1 | Write enable of port A |
| wa_addr | input | ADDR_W | Write address of port A |
| wa_data | input | DATA_W | Write data of port A |
| wb_en | input | 1 | Write enable of port B (wins a same-address collision) |
| wb_addr | input | ADDR_W | Write address of port B |
| wb_data | input | DATA_W | Write data of port B |
| rd_addr | input | NUM_RD*ADDR_W | Packed read addresses, one field per read port |
| rd_data | output | NUM_RD*DATA_W | Packed read data, one field per read port |

## Verification
The hardest case to reach is an address that holds different values in its two bank groups, where only the tag decides which value is seen. This is most visible after a reset, when every tag falls back to port A while port B's newer data still sits in storage. The stimulus writes one address through A, overwrites it through B, and pulses reset. It then expects the older port A value. Random traffic limited to eight addresses produces frequent same-address collisions and reads of addresses being written, and these are compared against a single-array model.

// File: rtl/rf_lvt_pkg.sv
package rf_lvt_pkg;

  // Read ports offered by one storage bank.
  localparam int unsigned BANK_RD = 3;

  // Identity of the write port that last wrote an address.
  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } wsrc_e;

  // Number of bank copies per write port needed for n read ports.
  function automatic int unsigned copies_for(input int unsigned n);
    return (n + BANK_RD - 1) / BANK_RD;
  endfunction

endpackage

// File: rtl/rf_bank3r1w.sv
module rf_bank3r1w
  import rf_lvt_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           waddr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [BANK_RD*ADDR_W-1:0]   raddr,
  output logic [BANK_RD*DATA_W-1:0]   rdata
);

  logic [DATA_W-1:0] mem_q [NUM_REGS];

  // Clocked write, enable written out; contents are not reset.
  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  // Combinational reads, one per bank slot.
  for (genvar s = 0; s < BANK_RD; s++) begin : g_rd
    assign rdata[s*DATA_W +: DATA_W] = mem_q[raddr[s*ADDR_W +: ADDR_W]];
  end

endmodule

// File: rtl/rf_lvt_tags.sv
module rf_lvt_tags
  import rf_lvt_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wa_en,
  input  logic [ADDR_W-1:0]   wa_addr,
  input  logic                wb_en,
  input  logic [ADDR_W-1:0]   wb_addr,
  output logic                a_we,
  output logic                b_we,
  output logic [NUM_REGS-1:0] tag_q
);

  logic [NUM_REGS-1:0] tag_d;
  logic                tag_en;
  logic                collide;

  // Next-state: arbitration and the tag update.
  always_comb begin
    collide = wa_en && wb_en && (wa_addr == wb_addr);
    a_we    = wa_en && !collide;
    b_we    = wb_en;
    tag_d   = tag_q;
    if (a_we) begin
      tag_d[wa_addr] = SRC_A;
    end
    if (b_we) begin
      tag_d[wb_addr] = SRC_B;
    end
    tag_en  = a_we || b_we;
  end

  // State register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (tag_en) begin
      tag_q <= tag_d;
    end
  end

endmodule

// File: rtl/rf_lvt_rdport.sv
module rf_lvt_rdport
  import rf_lvt_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = $clog2(NUM_REGS),
  parameter bit          REG_OUT  = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_REGS-1:0] tag_q,
  input  logic [DATA_W-1:0]   data_a,
  input  logic [DATA_W-1:0]   data_b,
  output logic [DATA_W-1:0]   sel_data,
  output logic [DATA_W-1:0]   out_data
);

  always_comb begin
    sel_data = (tag_q[addr] == SRC_B) ? data_b : data_a;
  end

  if (REG_OUT) begin : g_reg
    logic [DATA_W-1:0] out_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q <= '0;
      end else begin
        out_q <= sel_data;
      end
    end
    assign out_data = out_q;
  end else begin : g_comb
    assign out_data = sel_data;
  end

endmodule

// File: rtl/rf_lvt_top.sv
module rf_lvt_top
  import rf_lvt_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_RD   = 6,
  parameter bit          REG_OUT  = 1'b0,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wa_en,
  input  logic [ADDR_W-1:0]          wa_addr,
  input  logic [DATA_W-1:0]          wa_data,
  input  logic                       wb_en,
  input  logic [ADDR_W-1:0]          wb_addr,
  input  logic [DATA_W-1:0]          wb_data,
  input  logic [NUM_RD*ADDR_W-1:0]   rd_addr,
  output logic [NUM_RD*DATA_W-1:0]   rd_data
);

  localparam int unsigned NCOPY = copies_for(NUM_RD);
  localparam int unsigned NSLOT = NCOPY * BANK_RD;

  logic                       a_we;
  logic                       b_we;
  logic [NUM_REGS-1:0]        tag_q;
  logic [NSLOT*ADDR_W-1:0]    raddr_pad;
  logic [NSLOT*DATA_W-1:0]    rdat_a;
  logic [NSLOT*DATA_W-1:0]    rdat_b;
  logic [NUM_RD*DATA_W-1:0]   rd_sel_all;

  // Read addresses padded to a whole number of bank slots.
  assign raddr_pad[NUM_RD*ADDR_W-1:0] = rd_addr;
  if (NSLOT > NUM_RD) begin : g_pad
    assign raddr_pad[NSLOT*ADDR_W-1:NUM_RD*ADDR_W] = '0;
  end

  rf_lvt_tags #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
  ) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wa_en   (wa_en),
    .wa_addr (wa_addr),
    .wb_en   (wb_en),
    .wb_addr (wb_addr),
    .a_we    (a_we),
    .b_we    (b_we),
    .tag_q   (tag_q)
  );

  // One bank group per write port, NCOPY copies each.
  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    rf_bank3r1w #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W)
    ) u_bank_a (
      .clk   (clk),
      .we    (a_we),
      .waddr (wa_addr),
      .wdata (wa_data),
      .raddr (raddr_pad[c*BANK_RD*ADDR_W +: BANK_RD*ADDR_W]),
      .rdata (rdat_a[c*BANK_RD*DATA_W +: BANK_RD*DATA_W])
    );
    rf_bank3r1w #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W)
    ) u_bank_b (
      .clk   (clk),
      .we    (b_we),
      .waddr (wb_addr),
      .wdata (wb_data),
      .raddr (raddr_pad[c*BANK_RD*ADDR_W +: BANK_RD*ADDR_W]),
      .rdata (rdat_b[c*BANK_RD*DATA_W +: BANK_RD*DATA_W])
    );
  end

  // Read port r sits in copy r/BANK_RD, slot r%BANK_RD: flat slot r.
  for (genvar r = 0; r < NUM_RD; r++) begin : g_rp
    rf_lvt_rdport #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .REG_OUT  (REG_OUT)
    ) u_rp (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (rd_addr[r*ADDR_W +: ADDR_W]),
      .tag_q    (tag_q),
      .data_a   (rdat_a[r*DATA_W +: DATA_W]),
      .data_b   (rdat_b[r*DATA_W +: DATA_W]),
      .sel_data (rd_sel_all[r*DATA_W +: DATA_W]),
      .out_data (rd_data[r*DATA_W +: DATA_W])
    );
  end

endmodule

// File: rtl/rf_lvt_chk.sv
module rf_lvt_chk #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_RD   = 6,
  parameter bit          REG_OUT  = 1'b0,
  parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wa_en,
  input logic [ADDR_W-1:0]         wa_addr,
  input logic                      wb_en,
  input logic [ADDR_W-1:0]         wb_addr,
  input logic [NUM_REGS-1:0]       tag_q,
  input logic [NUM_RD*DATA_W-1:0]  rd_sel_all,
  input logic [NUM_RD*DATA_W-1:0]  rd_data
);

  // R2: uncontested port A write marks the address as port A's.
  p_tag_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && !(wb_en && (wb_addr == wa_addr))) |=> (tag_q[$past(wa_addr)] == 1'b0));

  // R3 and R4: any port B write, collision or not, marks port B.
  p_tag_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> (tag_q[$past(wb_addr)] == 1'b1));

  // R9: no enabled write leaves the tag table untouched.
  p_tag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wa_en && !wb_en) |=> $stable(tag_q));

  // R8: first edge out of reset sees an all-port-A table.
  p_tag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tag_q == '0));

  if (REG_OUT) begin : g_reg_chk
    // R7: registered output trails the selected value by one cycle.
    p_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (rd_data === $past(rd_sel_all)));
  end

endmodule

bind rf_lvt_top rf_lvt_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .NUM_RD   (NUM_RD),
  .REG_OUT  (REG_OUT),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wa_en      (wa_en),
  .wa_addr    (wa_addr),
  .wb_en      (wb_en),
  .wb_addr    (wb_addr),
  .tag_q      (tag_q),
  .rd_sel_all (rd_sel_all),
  .rd_data    (rd_data)
);

// File: tb/rf_lvt_top_tb.sv
`timescale 1ns/1ps
module rf_lvt_top_tb;

  localparam int NREG = 32;
  localparam int DW   = 32;
  localparam int NRD  = 6;
  localparam int AW   = 5;

  typedef struct packed {
    logic          ae;
    logic [AW-1:0] aa;
    logic [DW-1:0] ad;
    logic          be;
    logic [AW-1:0] ba;
    logic [DW-1:0] bd;
  } step_t;

  localparam int NSTEP = 12;
  localparam step_t TBL [NSTEP] = '{
    '{1'b1, 5'd1,  32'h1111_1111, 1'b0, 5'd1,  32'hDEAD_0001}, // R9 B off
    '{1'b0, 5'd2,  32'hBAD0_0002, 1'b1, 5'd2,  32'h2222_2222}, // R9 A off
    '{1'b1, 5'd4,  32'h0000_0044, 1'b1, 5'd5,  32'h0000_0055}, // R6
    '{1'b1, 5'd6,  32'h0A0A_0006, 1'b1, 5'd6,  32'h0B0B_0006}, // R4
    '{1'b1, 5'd6,  32'h0A0A_0066, 1'b0, 5'd6,  32'hDEAD_0066}, // R2
    '{1'b0, 5'd1,  32'hDEAD_0101, 1'b1, 5'd1,  32'h0B0B_0001}, // R3
    '{1'b1, 5'd1,  32'h0A0A_0011, 1'b1, 5'd1,  32'h0B0B_0011}, // R4
    '{1'b1, 5'd0,  32'hA000_0000, 1'b1, 5'd31, 32'hB000_001F}, // R6
    '{1'b0, 5'd3,  32'hDEAD_0003, 1'b0, 5'd7,  32'hDEAD_0007}, // R9
    '{1'b1, 5'd31, 32'hA000_001F, 1'b1, 5'd0,  32'hB000_0000}, // R6
    '{1'b1, 5'd5,  32'hA000_0005, 1'b1, 5'd4,  32'hB000_0004}, // R6
    '{1'b1, 5'd2,  32'hA000_0002, 1'b0, 5'd0,  32'hDEAD_0000}  // R2
  };

  logic                 clk;
  logic                 rst_n;
  logic                 wa_en, wb_en;
  logic [AW-1:0]        wa_addr, wb_addr;
  logic [DW-1:0]        wa_data, wb_data;
  logic [AW-1:0]        ra [NRD];
  logic [NRD*AW-1:0]    rd_addr;
  logic [NRD*DW-1:0]    rd_c, rd_r;

  logic [DW-1:0] model   [NREG];
  logic [DW-1:0] a_store [NREG];
  logic [DW-1:0] exp_prev [NRD];

  int  total, bad;
  bit  done;
  bit  chk_on;

  for (genvar p = 0; p < NRD; p++) begin : g_ra
    assign rd_addr[p*AW +: AW] = ra[p];
  end

  rf_lvt_top #(.NUM_REGS(NREG), .DATA_W(DW), .NUM_RD(NRD), .REG_OUT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .rd_addr(rd_addr), .rd_data(rd_c)
  );

  rf_lvt_top #(.NUM_REGS(NREG), .DATA_W(DW), .NUM_RD(NRD), .REG_OUT(1'b1)) u_dut_reg (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .rd_addr(rd_addr), .rd_data(rd_r)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int port, input logic [DW-1:0] got,
                     input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s port%0d got=%h exp=%h", req, port, got, exp);
    end
  endtask

  // Drive at negedge, check combinational reads before the edge (old
  // contents), check the registered copy after the edge, update the model.
  task automatic step(input logic ae, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                      input logic be, input logic [AW-1:0] ba, input logic [DW-1:0] bd,
                      input string req);
    @(negedge clk);
    wa_en = ae; wa_addr = aa; wa_data = ad;
    wb_en = be; wb_addr = ba; wb_data = bd;
    #1;
    for (int p = 0; p < NRD; p++) begin
      exp_prev[p] = model[ra[p]];
      if (chk_on) chk({req, " R1 R5 R10 comb"}, p, rd_c[p*DW +: DW], exp_prev[p]);
    end
    @(posedge clk);
    #1;
    if (chk_on)
      for (int p = 0; p < NRD; p++) chk("R7 registered", p, rd_r[p*DW +: DW], exp_prev[p]);
    if (ae && !(be && aa == ba)) begin
      model[aa]   = ad;
      a_store[aa] = ad;
    end
    if (be) model[ba] = bd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 1'b0; chk_on = 1'b0;
    rst_n = 1'b0;
    wa_en = 1'b0; wb_en = 1'b0;
    wa_addr = '0; wb_addr = '0; wa_data = '0; wb_data = '0;
    for (int p = 0; p < NRD; p++) ra[p] = '0;
    repeat (2) @(posedge clk);
    #1;
    // R7: registered outputs are zero while reset is held.
    for (int p = 0; p < NRD; p++) chk("R7 reset value", p, rd_r[p*DW +: DW], '0);
    @(negedge clk);
    rst_n = 1'b1;

    // Fill every register through port A.
    for (int i = 0; i < NREG; i++)
      step(1'b1, AW'(i), 32'hC0DE_0000 ^ (i * 32'h0101_0101), 1'b0, '0, '0, "init");
    chk_on = 1'b1;

    // Vector table walk: reads on ports 0/1 hit the write addresses (R5).
    for (int i = 0; i < NSTEP; i++) begin
      ra[0] = TBL[i].aa;
      ra[1] = TBL[i].ba;
      for (int p = 2; p < NRD; p++) ra[p] = AW'((i * 7 + p * 5) % NREG);
      step(TBL[i].ae, TBL[i].aa, TBL[i].ad, TBL[i].be, TBL[i].ba, TBL[i].bd,
           "table R2 R3 R4 R6 R9");
    end
    // Read back every touched address after the table.
    ra[0] = 5'd1; ra[1] = 5'd2; ra[2] = 5'd4; ra[3] = 5'd5; ra[4] = 5'd6; ra[5] = 5'd31;
    step(1'b0, 5'd3, 32'hDEAD_BEEF, 1'b0, 5'd3, 32'hDEAD_BEEF, "readback R4 R6 R9");

    // R8: address 3 written by A then by B, then reset.
    ra[0] = 5'd3;
    step(1'b1, 5'd3, 32'hAAAA_0003, 1'b0, '0, '0, "R8 setup A");
    step(1'b0, '0, '0, 1'b1, 5'd3, 32'hBBBB_0003, "R8 setup B");
    step(1'b0, '0, '0, 1'b0, '0, '0, "R3 newest is B");
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NREG; i++) model[i] = a_store[i];
    ra[0] = 5'd3; ra[1] = 5'd6; ra[2] = 5'd1; ra[3] = 5'd0; ra[4] = 5'd31; ra[5] = 5'd4;
    #1;
    for (int p = 0; p < NRD; p++)
      chk("R8 tags back to A", p, rd_c[p*DW +: DW], a_store[ra[p]]);
    chk("R8 addr3 holds A value", 0, rd_c[DW-1:0], 32'hAAAA_0003);
    // The registered copy was cleared by reset; its next value is checked in step.
    step(1'b0, '0, '0, 1'b0, '0, '0, "R8 after reset");

    // Random traffic on 8 addresses: frequent collisions and read-during-write.
    for (int n = 0; n < 400; n++) begin
      for (int p = 0; p < NRD; p++) ra[p] = AW'($urandom % 8);
      step(1'($urandom), AW'($urandom % 8), DW'($urandom),
           1'($urandom), AW'($urandom % 8), DW'($urandom), "random R4 R5 R10");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule